// File: doc/BRIEF.md
# Counter-Block Streaming Cipher Engine

This block is a slave on an external-memory bus with byte data and 16-bit addresses. Software loads a buffer address, a buffer length, a 128-bit counter and two 128-bit keys one byte at a time through a 64-byte register window. It then writes a start bit. The engine walks the buffer in 16-byte blocks. For each block it fetches the bytes from memory and hands the block, the counter and both keys to an external cipher unit over a valid/ready port. It then writes the 16 result bytes back over the same addresses.

A four-state sequencer (idle, fetch, cipher, write-back) drives a single-port byte-wide memory master. The master moves one byte per enabled cycle. Bit 0 of the bus operation input is a step enable, and the sequencer moves only in cycles where it is high. Register writes are accepted only while the sequencer is idle, so a run in progress cannot be disturbed by software.

Top module: `ctr_stream_engine`

## Requirements
- R1: Addresses 0xFF00 to 0xFF3F inclusive raise `bus_claim`; any other address leaves it low. While `bus_claim` is low, `bus_rdata` is 0.
- R2: A bus read of offset 0x01 returns the sequencer state as idle=0, fetch=1, cipher=2, write-back=3, with bits 7:2 zero. The state is idle after reset.
- R3: The 16-bit buffer address sits at offsets 0x02/0x03 and the 16-bit length at 0x04/0x05. Address bit 0 = 0 selects bits 7:0 and bit 0 = 1 selects bits 15:8. Both are readable and writable, and both reset to 0.
- R4: The counter sits at offsets 0x10-0x1F, key 0 at 0x20-0x2F and key 1 at 0x30-0x3F. Address bits 3:0 = n select bits 8n+7:8n. All three are readable and writable, and all reset to 0.
- R5: A register write made while the state is not idle has no effect.
- R6: A write to offset 0x00 with data bit 0 = 1 while idle enters fetch with the processed count cleared. A write there with data bit 0 = 0 leaves the state idle.
- R7: Outside idle, the state, the byte index and the memory request change only in cycles where `bus_op[0]` = 1. `bus_op[1]` is ignored.
- R8: Fetch issues 16 reads, one per stepped cycle, at base+0 to base+15. Byte i lands in bits 8i+7:8i of `cph_blk`. The first base is the buffer address.
- R9: In the cipher state `cph_valid` is 1 and `cph_blk` is stable. The state leaves for write-back only in a cycle where `cph_ready` = 1 and `bus_op[0]` = 1. In that cycle `cph_result` is captured and the processed count grows by 16.
- R10: Write-back stores result byte i (bits 8i+7:8i) at base+i. These are the same addresses the block was fetched from.
- R11: After the 16th write, the engine returns to fetch with base+16 if processed < length; otherwise it returns to idle. A length of 0 therefore processes one block. Each block takes 33 stepped cycles.
- R12: `bus_op[3:2]` = 1 is a read and 2 is a write. The values 0 and 3 neither change a register nor return data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_op | input | 4 | [3:2] access kind, [1] ignored, [0] step enable |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data (combinational) |
| bus_claim | output | 1 | Address lies in the register window |
| mem_req | output | 1 | Memory byte transfer this cycle |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, same cycle as the request |
| cph_valid | output | 1 | Cipher request pending |
| cph_blk | output | 128 | Fetched data block |
| cph_ctr | output | 128 | Counter value |
| cph_key0 | output | 128 | Key 0 |
| cph_key1 | output | 128 | Key 1 |
| cph_ready | input | 1 | Cipher result available |
| cph_result | input | 128 | Cipher result block |

## Verification
The bench uses the default parameters: 16-byte blocks, a 16-bit address and the window at 0xFF00. With these, a 40-byte length exercises a three-block run whose last block passes the length. It checks the 33-cycle block rhythm exactly. A second zero-length run shows the single-block case. During that run the step enable is held low in fetch, the cipher ready is held low in the cipher state, and a key write is attempted while busy. The cipher stub XORs the block with the counter and both keys, so every rewritten byte has a value the bench can predict.

// File: rtl/cse_pkg.sv
package cse_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_OP    = 2'd2,
        ST_WRITE = 2'd3
    } seq_st_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_START,
        SEL_STATE,
        SEL_ADDR,
        SEL_LEN,
        SEL_CTR,
        SEL_KEY0,
        SEL_KEY1
    } reg_sel_e;

    // bus access kinds carried in bus_op[3:2]
    localparam logic [1:0] BUSK_READ  = 2'd1;
    localparam logic [1:0] BUSK_WRITE = 2'd2;

    // offsets inside the control slot (slot 0)
    localparam logic [3:0] OFS_START = 4'd0;
    localparam logic [3:0] OFS_STATE = 4'd1;
    localparam logic [3:0] OFS_ADDR  = 4'd2;
    localparam logic [3:0] OFS_LEN   = 4'd4;

endpackage

// File: rtl/cse_decode.sv
module cse_decode
    import cse_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                BLK_BYTES = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'hFF00
) (
    input  logic [1:0]                     bus_kind,
    input  logic [ADDR_W-1:0]              bus_addr,
    output logic                           hit,
    output logic                           rd,
    output logic                           wr,
    output reg_sel_e                       sel,
    output logic [$clog2(BLK_BYTES)-1:0]   lane
);
    localparam int                IDX_W    = $clog2(BLK_BYTES);
    localparam int                OFF_W    = IDX_W + 2;
    localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(4 * BLK_BYTES);

    logic [ADDR_W-1:0] rel;
    logic [1:0]        slot;
    logic [IDX_W-1:0]  ofs;

    always_comb begin
        rel  = bus_addr - WIN_BASE;
        hit  = (bus_addr >= WIN_BASE) && (rel < WIN_SPAN);
        slot = rel[OFF_W-1:IDX_W];
        ofs  = rel[IDX_W-1:0];
        lane = ofs;
        rd   = hit && (bus_kind == BUSK_READ);
        wr   = hit && (bus_kind == BUSK_WRITE);
        sel  = SEL_NONE;
        if (hit) begin
            case (slot)
                2'd0: begin
                    if (ofs == IDX_W'(OFS_START))                     sel = SEL_START;
                    else if (ofs == IDX_W'(OFS_STATE))                sel = SEL_STATE;
                    else if ({ofs[IDX_W-1:1], 1'b0} == IDX_W'(OFS_ADDR)) sel = SEL_ADDR;
                    else if ({ofs[IDX_W-1:1], 1'b0} == IDX_W'(OFS_LEN))  sel = SEL_LEN;
                    else                                              sel = SEL_NONE;
                end
                2'd1:    sel = SEL_CTR;
                2'd2:    sel = SEL_KEY0;
                default: sel = SEL_KEY1;
            endcase
        end
    end

endmodule

// File: rtl/cse_regfile.sv
module cse_regfile
    import cse_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BLK_BYTES = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  reg_sel_e                      sel,
    input  logic [$clog2(BLK_BYTES)-1:0]  lane,
    input  logic [7:0]                    wdata,
    input  seq_st_e                       state,
    output logic [7:0]                    rdata,
    output logic [ADDR_W-1:0]             buf_addr,
    output logic [ADDR_W-1:0]             buf_len,
    output logic [BLK_BYTES*8-1:0]        ctr,
    output logic [BLK_BYTES*8-1:0]        key0,
    output logic [BLK_BYTES*8-1:0]        key1
);
    localparam int BLK_W = BLK_BYTES * 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] len;
        logic [BLK_W-1:0]  ctr;
        logic [BLK_W-1:0]  key0;
        logic [BLK_W-1:0]  key1;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (sel)
                SEL_ADDR: r_d.addr[{lane[0], 3'b000} +: 8] = wdata;
                SEL_LEN:  r_d.len[{lane[0], 3'b000} +: 8]  = wdata;
                SEL_CTR:  r_d.ctr[{lane, 3'b000} +: 8]     = wdata;
                SEL_KEY0: r_d.key0[{lane, 3'b000} +: 8]    = wdata;
                SEL_KEY1: r_d.key1[{lane, 3'b000} +: 8]    = wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_STATE: rdata = {6'b000000, state};
                SEL_ADDR:  rdata = r_q.addr[{lane[0], 3'b000} +: 8];
                SEL_LEN:   rdata = r_q.len[{lane[0], 3'b000} +: 8];
                SEL_CTR:   rdata = r_q.ctr[{lane, 3'b000} +: 8];
                SEL_KEY0:  rdata = r_q.key0[{lane, 3'b000} +: 8];
                SEL_KEY1:  rdata = r_q.key1[{lane, 3'b000} +: 8];
                default:   rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign buf_addr = r_q.addr;
    assign buf_len  = r_q.len;
    assign ctr      = r_q.ctr;
    assign key0     = r_q.key0;
    assign key1     = r_q.key1;

endmodule

// File: rtl/cse_sequencer.sv
module cse_sequencer
    import cse_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BLK_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    step,
    input  logic [ADDR_W-1:0]       buf_addr,
    input  logic [ADDR_W-1:0]       buf_len,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [7:0]              mem_wdata,
    input  logic [7:0]              mem_rdata,
    output logic                    cph_valid,
    output logic [BLK_BYTES*8-1:0]  cph_blk,
    input  logic                    cph_ready,
    input  logic [BLK_BYTES*8-1:0]  cph_result,
    output seq_st_e                 state
);
    localparam int BLK_W = BLK_BYTES * 8;
    localparam int IDX_W = $clog2(BLK_BYTES);

    typedef struct packed {
        seq_st_e           st;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] done;
        logic [ADDR_W-1:0] base;
        logic [BLK_W-1:0]  blk;
        logic [BLK_W-1:0]  res;
    } seq_t;

    seq_t s_d, s_q;
    logic last;

    always_comb begin
        s_d  = s_q;
        last = (s_q.idx == IDX_W'(BLK_BYTES - 1));
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st   = ST_READ;
                    s_d.done = '0;
                    s_d.base = buf_addr;
                    s_d.idx  = '0;
                end
            end
            ST_READ: begin
                if (step) begin
                    s_d.blk[{s_q.idx, 3'b000} +: 8] = mem_rdata;
                    s_d.idx = s_q.idx + 1'b1;
                    if (last) s_d.st = ST_OP;
                end
            end
            ST_OP: begin
                if (step && cph_ready) begin
                    s_d.res  = cph_result;
                    s_d.done = s_q.done + ADDR_W'(BLK_BYTES);
                    s_d.st   = ST_WRITE;
                end
            end
            default: begin
                if (step) begin
                    s_d.idx = s_q.idx + 1'b1;
                    if (last) begin
                        if (s_q.done < buf_len) begin
                            s_d.st   = ST_READ;
                            s_d.base = s_q.base + ADDR_W'(BLK_BYTES);
                        end else begin
                            s_d.st = ST_IDLE;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req   = step && ((s_q.st == ST_READ) || (s_q.st == ST_WRITE));
    assign mem_we    = step && (s_q.st == ST_WRITE);
    assign mem_addr  = s_q.base + ADDR_W'(s_q.idx);
    assign mem_wdata = s_q.res[{s_q.idx, 3'b000} +: 8];
    assign cph_valid = (s_q.st == ST_OP);
    assign cph_blk   = s_q.blk;
    assign state     = s_q.st;

endmodule

// File: rtl/ctr_stream_engine.sv
module ctr_stream_engine
    import cse_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                BLK_BYTES = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'hFF00
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [3:0]              bus_op,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    output logic                    bus_claim,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [7:0]              mem_wdata,
    input  logic [7:0]              mem_rdata,
    output logic                    cph_valid,
    output logic [BLK_BYTES*8-1:0]  cph_blk,
    output logic [BLK_BYTES*8-1:0]  cph_ctr,
    output logic [BLK_BYTES*8-1:0]  cph_key0,
    output logic [BLK_BYTES*8-1:0]  cph_key1,
    input  logic                    cph_ready,
    input  logic [BLK_BYTES*8-1:0]  cph_result
);
    localparam int IDX_W = $clog2(BLK_BYTES);

    logic              dec_rd;
    logic              dec_wr;
    reg_sel_e          dec_sel;
    logic [IDX_W-1:0]  dec_lane;
    logic              wr_ok;
    logic              start;
    logic [ADDR_W-1:0] buf_addr;
    logic [ADDR_W-1:0] buf_len;
    seq_st_e           seq_state;
    logic              op_unused;

    assign op_unused = bus_op[1];

    cse_decode #(
        .ADDR_W    (ADDR_W),
        .BLK_BYTES (BLK_BYTES),
        .WIN_BASE  (WIN_BASE)
    ) u_decode (
        .bus_kind (bus_op[3:2]),
        .bus_addr (bus_addr),
        .hit      (bus_claim),
        .rd       (dec_rd),
        .wr       (dec_wr),
        .sel      (dec_sel),
        .lane     (dec_lane)
    );

    // writes land only while the sequencer rests
    assign wr_ok = dec_wr && (seq_state == ST_IDLE);
    assign start = wr_ok && (dec_sel == SEL_START) && bus_wdata[0];

    cse_regfile #(
        .ADDR_W    (ADDR_W),
        .BLK_BYTES (BLK_BYTES)
    ) u_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ok),
        .rd_en    (dec_rd),
        .sel      (dec_sel),
        .lane     (dec_lane),
        .wdata    (bus_wdata),
        .state    (seq_state),
        .rdata    (bus_rdata),
        .buf_addr (buf_addr),
        .buf_len  (buf_len),
        .ctr      (cph_ctr),
        .key0     (cph_key0),
        .key1     (cph_key1)
    );

    cse_sequencer #(
        .ADDR_W    (ADDR_W),
        .BLK_BYTES (BLK_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .step       (bus_op[0]),
        .buf_addr   (buf_addr),
        .buf_len    (buf_len),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .cph_valid  (cph_valid),
        .cph_blk    (cph_blk),
        .cph_ready  (cph_ready),
        .cph_result (cph_result),
        .state      (seq_state)
    );

endmodule

// File: rtl/cse_checker.sv
module cse_checker #(
    parameter int                ADDR_W    = 16,
    parameter int                BLK_BYTES = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'hFF00
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             bus_kind,
    input logic                   step,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [7:0]             bus_rdata,
    input logic                   bus_claim,
    input logic                   mem_req,
    input logic                   cph_valid,
    input logic                   cph_ready,
    input logic [BLK_BYTES*8-1:0] cph_blk,
    input logic [1:0]             seq_state
);
    localparam logic [ADDR_W-1:0] STATE_ADDR = WIN_BASE + ADDR_W'(1);

    AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_claim |-> bus_rdata == 8'h00); // R1

    AST_STATE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_kind == 2'd1 && bus_addr == STATE_ADDR) |-> bus_rdata == {6'b000000, seq_state}); // R2

    AST_NON_READ_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_kind != 2'd1 |-> bus_rdata == 8'h00); // R12

    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != 2'd0 && !step) |=> $stable(seq_state)); // R7

    AST_NO_STEP_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        !step |-> !mem_req); // R7

    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state == 2'd0 |-> !mem_req); // R8

    AST_OP_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cph_valid && !(cph_ready && step)) |=> cph_valid); // R9

    AST_OP_BLOCK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cph_valid && $past(cph_valid)) |-> $stable(cph_blk)); // R9

    AST_OP_EXIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seq_state) == 2'd2 && seq_state == 2'd3) |-> $past(cph_ready && step)); // R9

endmodule

bind ctr_stream_engine cse_checker #(
    .ADDR_W    (ADDR_W),
    .BLK_BYTES (BLK_BYTES),
    .WIN_BASE  (WIN_BASE)
) u_cse_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_kind  (bus_op[3:2]),
    .step      (bus_op[0]),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_claim (bus_claim),
    .mem_req   (mem_req),
    .cph_valid (cph_valid),
    .cph_ready (cph_ready),
    .cph_blk   (cph_blk),
    .seq_state (seq_state)
);

// File: tb/test_ctr_stream_engine.sv
module test_ctr_stream_engine;

    localparam int          ADDR_W    = 16;
    localparam int          BLK_BYTES = 16;
    localparam int          BLK_W     = BLK_BYTES * 8;
    localparam logic [15:0] WIN_BASE  = 16'hFF00;

    localparam logic [3:0] OP_W = 4'b1000;
    localparam logic [3:0] OP_R = 4'b0100;
    localparam logic [3:0] OP_X = 4'b1100;
    localparam logic [3:0] OP_N = 4'b0000;

    // {req, op, addr, wdata, expected rdata, expected claim}
    localparam int NVEC = 26;
    localparam logic [40:0] VEC [NVEC] = '{
        {4'd3,  OP_W, 16'hFF02, 8'h34, 8'h00, 1'b1},
        {4'd3,  OP_W, 16'hFF03, 8'h12, 8'h00, 1'b1},
        {4'd3,  OP_R, 16'hFF02, 8'h00, 8'h34, 1'b1},
        {4'd3,  OP_R, 16'hFF03, 8'h00, 8'h12, 1'b1},
        {4'd3,  OP_W, 16'hFF04, 8'h28, 8'h00, 1'b1},
        {4'd3,  OP_W, 16'hFF05, 8'h00, 8'h00, 1'b1},
        {4'd3,  OP_R, 16'hFF04, 8'h00, 8'h28, 1'b1},
        {4'd4,  OP_W, 16'hFF10, 8'hA5, 8'h00, 1'b1},
        {4'd4,  OP_W, 16'hFF1F, 8'h3C, 8'h00, 1'b1},
        {4'd4,  OP_R, 16'hFF10, 8'h00, 8'hA5, 1'b1},
        {4'd4,  OP_R, 16'hFF1F, 8'h00, 8'h3C, 1'b1},
        {4'd4,  OP_R, 16'hFF11, 8'h00, 8'h00, 1'b1},
        {4'd4,  OP_W, 16'hFF20, 8'h11, 8'h00, 1'b1},
        {4'd4,  OP_W, 16'hFF2F, 8'h22, 8'h00, 1'b1},
        {4'd4,  OP_W, 16'hFF30, 8'h44, 8'h00, 1'b1},
        {4'd4,  OP_W, 16'hFF37, 8'h66, 8'h00, 1'b1},
        {4'd4,  OP_R, 16'hFF2F, 8'h00, 8'h22, 1'b1},
        {4'd4,  OP_R, 16'hFF37, 8'h00, 8'h66, 1'b1},
        {4'd4,  OP_R, 16'hFF3F, 8'h00, 8'h00, 1'b1},
        {4'd2,  OP_R, 16'hFF01, 8'h00, 8'h00, 1'b1},
        {4'd1,  OP_R, 16'hFF40, 8'h00, 8'h00, 1'b0},
        {4'd1,  OP_R, 16'hFEFF, 8'h00, 8'h00, 1'b0},
        {4'd12, OP_X, 16'hFF02, 8'h77, 8'h00, 1'b1},
        {4'd12, OP_N, 16'hFF03, 8'h99, 8'h00, 1'b1},
        {4'd12, OP_R, 16'hFF02, 8'h00, 8'h34, 1'b1},
        {4'd12, OP_R, 16'hFF03, 8'h00, 8'h12, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       bus_op = '0;
    logic [15:0]      bus_addr = '0;
    logic [7:0]       bus_wdata = '0;
    logic [7:0]       bus_rdata;
    logic             bus_claim;
    logic             mem_req;
    logic             mem_we;
    logic [15:0]      mem_addr;
    logic [7:0]       mem_wdata;
    logic [7:0]       mem_rdata;
    logic             cph_valid;
    logic [BLK_W-1:0] cph_blk;
    logic [BLK_W-1:0] cph_ctr;
    logic [BLK_W-1:0] cph_key0;
    logic [BLK_W-1:0] cph_key1;
    logic             cph_ready = 1'b1;
    logic [BLK_W-1:0] cph_result;

    logic [7:0] mem [0:1023];

    int n_chk = 0;
    int n_bad = 0;

    always #10ns clk = ~clk;

    ctr_stream_engine #(
        .ADDR_W    (ADDR_W),
        .BLK_BYTES (BLK_BYTES),
        .WIN_BASE  (WIN_BASE)
    ) i_ctr_stream_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_op     (bus_op),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_claim  (bus_claim),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .cph_valid  (cph_valid),
        .cph_blk    (cph_blk),
        .cph_ctr    (cph_ctr),
        .cph_key0   (cph_key0),
        .cph_key1   (cph_key1),
        .cph_ready  (cph_ready),
        .cph_result (cph_result)
    );

    function automatic logic [7:0] orig_byte(input int a);
        return 8'(a * 13 + 5);
    endfunction

    // counter ^ key0 ^ key1 per lane, from the values the table programs
    function automatic logic [7:0] mask_byte(input int lane);
        case (lane)
            0:       return 8'hA5 ^ 8'h11 ^ 8'h44;
            7:       return 8'h66;
            15:      return 8'h3C ^ 8'h22;
            default: return 8'h00;
        endcase
    endfunction

    // memory model: combinational read, write on the clock edge
    assign mem_rdata  = mem[mem_addr[9:0]];
    assign cph_result = cph_blk ^ cph_ctr ^ cph_key0 ^ cph_key1;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= orig_byte(i);
        end else if (mem_req && mem_we) begin
            mem[mem_addr[9:0]] <= mem_wdata;
        end
    end

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_op    = op;
        bus_addr  = a;
        bus_wdata = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int busy;
        logic [BLK_W-1:0] exp_blk;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // reset state: R2 idle, R7 no traffic, R9 no request
        drive(OP_R, 16'hFF01, 8'h00);
        #1ns;
        check("R2 reset state", 128'(bus_rdata), 128'h0);
        check("R7 reset mem_req", 128'(mem_req), 128'h0);
        check("R9 reset cph_valid", 128'(cph_valid), 128'h0);
        drive(OP_R, 16'hFF05, 8'h00);
        #1ns;
        check("R3 reset length high byte", 128'(bus_rdata), 128'h0);

        // register table: R1 R3 R4 R12
        for (int v = 0; v < NVEC; v++) begin
            drive(VEC[v][36:33], VEC[v][32:17], VEC[v][16:9]);
            #1ns;
            check($sformatf("R%0d table row %0d rdata", VEC[v][40:37], v), 128'(bus_rdata), 128'(VEC[v][8:1]));
            check($sformatf("R1 table row %0d claim", v), 128'(bus_claim), 128'(VEC[v][0]));
        end

        // buffer at 0x0100, length stays 40
        drive(OP_W, 16'hFF02, 8'h00);
        drive(OP_W, 16'hFF03, 8'h01);

        // R6: start with bit 0 clear does nothing
        drive(OP_W, 16'hFF00, 8'h02);
        drive(OP_R, 16'hFF01, 8'h00);
        #1ns;
        check("R6 start bit clear stays idle", 128'(bus_rdata), 128'h0);

        // run 1: three blocks of 33 stepped cycles each
        drive(OP_W, 16'hFF00, 8'h01);
        busy = 0;
        for (int k = 0; k < 400; k++) begin
            drive(4'b0101, 16'hFF01, 8'h00);
            #1ns;
            if (bus_rdata == 8'h00) break;
            busy++;
        end
        check("R11 cycles for three-block run", 128'(busy), 128'(99));
        for (int j = 0; j < 48; j++)
            check($sformatf("R10 in-place byte %0d", j), 128'(mem[16'h0100 + j]),
                  128'(orig_byte(16'h0100 + j) ^ mask_byte(j % 16)));
        check("R11 byte past last block untouched", 128'(mem[16'h0130]), 128'(orig_byte(16'h0130)));
        check("R10 byte below buffer untouched", 128'(mem[16'h00FF]), 128'(orig_byte(16'h00FF)));

        // run 2: buffer 0x0200, length 0
        drive(OP_W, 16'hFF02, 8'h00);
        drive(OP_W, 16'hFF03, 8'h02);
        drive(OP_W, 16'hFF04, 8'h00);
        cph_ready = 1'b0;
        drive(OP_W, 16'hFF00, 8'h01);

        // R7: no step, nothing moves
        for (int k = 0; k < 5; k++) begin
            drive(OP_R, 16'hFF01, 8'h00);
            #1ns;
            check("R7 state held without step", 128'(bus_rdata), 128'h1);
            check("R7 no memory access without step", 128'(mem_req), 128'h0);
        end

        for (int k = 0; k < 16; k++) drive(4'b0001, 16'h0000, 8'h00);
        drive(OP_R, 16'hFF01, 8'h00);
        #1ns;
        check("R2 state after fetch", 128'(bus_rdata), 128'h2);
        check("R9 valid in cipher state", 128'(cph_valid), 128'h1);
        exp_blk = '0;
        for (int i = 0; i < 16; i++) exp_blk[i*8 +: 8] = orig_byte(16'h0200 + i);
        check("R8 fetched block order", cph_blk, exp_blk);

        // R9: ready low holds the cipher state even with step
        for (int k = 0; k < 3; k++) begin
            drive(4'b0101, 16'hFF01, 8'h00);
            #1ns;
            check("R9 waits for ready", 128'(bus_rdata), 128'h2);
        end

        // R5: key write while busy is dropped
        drive(OP_W, 16'hFF20, 8'hEE);

        drive(4'b0101, 16'hFF01, 8'h00);
        cph_ready = 1'b1;
        drive(4'b0101, 16'hFF01, 8'h00);
        #1ns;
        check("R2 state in write-back", 128'(bus_rdata), 128'h3);
        busy = 0;
        for (int k = 0; k < 40; k++) begin
            drive(4'b0101, 16'hFF01, 8'h00);
            #1ns;
            if (bus_rdata == 8'h00) break;
            busy++;
        end
        check("R11 zero length ends after one block", 128'(busy), 128'(15));
        for (int j = 0; j < 16; j++)
            check($sformatf("R10 zero-length run byte %0d", j), 128'(mem[16'h0200 + j]),
                  128'(orig_byte(16'h0200 + j) ^ mask_byte(j)));
        check("R11 next block untouched", 128'(mem[16'h0210]), 128'(orig_byte(16'h0210)));
        drive(OP_R, 16'hFF20, 8'h00);
        #1ns;
        check("R5 busy write ignored", 128'(bus_rdata), 128'h11);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule